// File: doc/BRIEF.md
# DSI command packet transmitter

This block turns one command request into pushes on two transmit queues: a header queue and a payload queue. A request carries a DSI data type, two parameter bytes and a length. Long payloads arrive afterwards on a byte stream with a valid/ready handshake.

Short write and peripheral-control types produce a single header holding the type and both parameter bytes. Long generic and DCS writes first pack their bytes into 32-bit payload words. After the last word, the block pushes a header that carries the byte count. It then waits for the downstream queue to report that it has drained, and gives up after a programmable number of cycles.

Types for video timing, null, blanking and pixel streams do not belong on a command path, so they are refused. Unlisted types are reported as unknown. Any request made while the link sits in ultra-low-power state is turned away. Each request ends with a one-cycle status pulse, and only one request is handled at a time.

Top module: `dsi_cmd_tx`

## Requirements
- R1: Long-write payload bytes are packed little-endian: byte 4k+n of the payload appears in bits 8n+7..8n of the k-th payload word pushed.
- R2: When the long payload length is not a multiple of four, the last word carries the remaining 1 to 3 bytes in its low lanes, and its unused upper bytes are zero.
- R3: A long write (type 0x29 or 0x39) pushes every payload word before its single header. That header has the type in bits 5:0, zero in bits 7:6, the length low byte in bits 15:8 and the length high byte in bits 23:16. A zero length pushes no payload word.
- R4: Types 0x03, 0x13, 0x23, 0x05, 0x15, 0x37, 0x02, 0x12, 0x22 and 0x32 each push exactly one header and no payload word. The header holds the type in bits 5:0, parameter byte 0 in bits 15:8 and parameter byte 1 in bits 23:16. The status returned is 0 (ok).
- R5: After the header of a long write, a drain event seen within TMO_CYCLES cycles ends the request with status 0. This includes an event on the last permitted cycle.
- R6: If no drain event arrives, the status is 4 (timeout). It is returned exactly TMO_CYCLES cycles after the header push cycle.
- R7: Types 0x01, 0x11, 0x21, 0x31, 0x08, 0x09, 0x19, 0x0E, 0x1E, 0x2E and 0x3E push nothing and return status 1 (refused).
- R8: Any other type pushes nothing and returns status 2 (unknown).
- R9: A request accepted while the low-power input is high pushes nothing and returns status 3, two cycles after acceptance, whatever its type.
- R10: Request-ready is low from the cycle after acceptance until the status pulse. The status pulse lasts one cycle, and ready is high again in that same cycle.
- R11: After reset, request-ready is high and no push or status is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_type | input | 6 | DSI data type |
| req_len | input | 16 | Long payload length in bytes |
| req_p0 | input | 8 | First short parameter byte |
| req_p1 | input | 8 | Second short parameter byte |
| link_lp | input | 1 | Link is in ultra-low-power state |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte taken when both high |
| byte_data | input | 8 | Payload byte |
| hdr_push | output | 1 | Header queue write strobe |
| hdr_data | output | 24 | Header word |
| pay_push | output | 1 | Payload queue write strobe |
| pay_data | output | 32 | Payload word |
| drain_evt | input | 1 | Downstream queue drained event |
| done_valid | output | 1 | One-cycle status pulse |
| done_code | output | 3 | Status: 0 ok, 1 refused, 2 unknown, 3 low power, 4 timeout |

## Verification
The hardest situation to reach from the ports is the exact edge of the drain wait. A drain event on the final permitted cycle must still succeed, and one cycle later it must time out. The bench shortens the limit to 40 cycles and times the drain pulse by counting from the header push it observes. It places the pulse at offsets 39 and 40, and random requests also draw offsets past the limit. Payload lengths 0 to 8 and one above 255 exercise zero fill and the length high byte, while random stalls on the byte stream move the word boundaries against the handshake.

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx #(
  parameter int TMO_CYCLES = 62_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_type,
  input  logic [15:0] req_len,
  input  logic [7:0]  req_p0,
  input  logic [7:0]  req_p1,
  input  logic        link_lp,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  output logic        hdr_push,
  output logic [23:0] hdr_data,
  output logic        pay_push,
  output logic [31:0] pay_data,
  input  logic        drain_evt,
  output logic        done_valid,
  output logic [2:0]  done_code
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TMO_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_PACK, S_HDR, S_WAIT} st_t;
  typedef enum logic [1:0] {K_SHORT, K_LONG, K_REF, K_UNK} kind_t;

  st_t         st;
  kind_t       kind;
  logic [5:0]  t_q;
  logic [15:0] len_q, rem;
  logic [7:0]  p0_q, p1_q;
  logic        lp_q;
  logic [31:0] word;
  logic [1:0]  lane;
  logic [TW-1:0] timer;
  logic [31:0] nxt_word;

  assign req_ready  = (st == S_IDLE);
  assign byte_ready = (st == S_PACK);
  assign nxt_word   = word | ({24'd0, byte_data} << {lane, 3'b000});

  always_comb begin
    case (t_q)
      6'h03, 6'h13, 6'h23, 6'h05, 6'h15, 6'h37,
      6'h02, 6'h12, 6'h22, 6'h32:                 kind = K_SHORT;
      6'h29, 6'h39:                               kind = K_LONG;
      6'h01, 6'h11, 6'h21, 6'h31, 6'h08, 6'h09,
      6'h19, 6'h0E, 6'h1E, 6'h2E, 6'h3E:          kind = K_REF;
      default:                                    kind = K_UNK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      t_q <= '0; len_q <= '0; p0_q <= '0; p1_q <= '0; lp_q <= 1'b0;
      rem <= '0; word <= '0; lane <= '0; timer <= '0;
      hdr_push <= 1'b0; hdr_data <= '0;
      pay_push <= 1'b0; pay_data <= '0;
      done_valid <= 1'b0; done_code <= '0;
    end else begin
      hdr_push   <= 1'b0;
      pay_push   <= 1'b0;
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          t_q <= req_type; len_q <= req_len;
          p0_q <= req_p0;  p1_q <= req_p1;
          lp_q <= link_lp;
          st <= S_DISP;
        end
        S_DISP: begin
          if (lp_q) begin
            done_valid <= 1'b1; done_code <= 3'd3; st <= S_IDLE;
          end else begin
            case (kind)
              K_SHORT: begin
                hdr_push <= 1'b1;
                hdr_data <= {p1_q, p0_q, 2'b00, t_q};
                done_valid <= 1'b1; done_code <= 3'd0; st <= S_IDLE;
              end
              K_LONG: begin
                word <= '0; lane <= '0; rem <= len_q;
                st <= (len_q == 16'd0) ? S_HDR : S_PACK;
              end
              K_REF: begin
                done_valid <= 1'b1; done_code <= 3'd1; st <= S_IDLE;
              end
              default: begin
                done_valid <= 1'b1; done_code <= 3'd2; st <= S_IDLE;
              end
            endcase
          end
        end
        S_PACK: if (byte_valid) begin
          rem <= rem - 16'd1;
          if (lane == 2'd3 || rem == 16'd1) begin
            pay_push <= 1'b1;
            pay_data <= nxt_word;
            word <= '0;
            lane <= '0;
          end else begin
            word <= nxt_word;
            lane <= lane + 2'd1;
          end
          if (rem == 16'd1) st <= S_HDR;
        end
        S_HDR: begin
          hdr_push <= 1'b1;
          hdr_data <= {len_q[15:8], len_q[7:0], 2'b00, t_q};
          timer <= '0;
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (drain_evt) begin
            done_valid <= 1'b1; done_code <= 3'd0; st <= S_IDLE;
          end else if (timer == TLAST) begin
            done_valid <= 1'b1; done_code <= 3'd4; st <= S_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsi_cmd_tx_chk.sv
module dsi_cmd_tx_chk #(
  parameter int TMO_CYCLES = 62_500_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        link_lp,
  input logic        byte_ready,
  input logic        hdr_push,
  input logic        pay_push,
  input logic        done_valid,
  input logic [2:0]  done_code
);
  logic        hdr_seen;
  logic [31:0] wcnt;
  wire acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_seen <= 1'b0;
      wcnt <= '0;
    end else begin
      if (acc) hdr_seen <= 1'b0;
      else if (hdr_push) hdr_seen <= 1'b1;
      if (done_valid) wcnt <= '0;
      else if (hdr_push) wcnt <= 32'd1;
      else if (wcnt != 0) wcnt <= wcnt + 32'd1;
    end
  end

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pay_push |-> !hdr_seen);
  p_tmo_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 3'd4) |-> wcnt == 32'(TMO_CYCLES));
  p_lp_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && link_lp) |=> ##1 (done_valid && done_code == 3'd3));
  p_lp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && link_lp) |=> (!hdr_push && !pay_push));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_ready);
  p_bytes_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !req_ready);
endmodule

bind dsi_cmd_tx dsi_cmd_tx_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .link_lp(link_lp), .byte_ready(byte_ready), .hdr_push(hdr_push),
  .pay_push(pay_push), .done_valid(done_valid), .done_code(done_code)
);

// File: tb/tb_dsi_cmd_tx.sv
module tb_dsi_cmd_tx;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, link_lp = 1'b0, byte_valid = 1'b0, drain_evt = 1'b0;
  logic [5:0] req_type = '0;
  logic [15:0] req_len = '0;
  logic [7:0] req_p0 = '0, req_p1 = '0, byte_data = '0;
  logic req_ready, byte_ready, hdr_push, pay_push, done_valid;
  logic [23:0] hdr_data;
  logic [31:0] pay_data;
  logic [2:0] done_code;

  int nchk = 0, nfail = 0;
  logic [7:0] pay [0:511];

  always #2 clk = ~clk;

  dsi_cmd_tx #(.TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_len(req_len), .req_p0(req_p0), .req_p1(req_p1),
    .link_lp(link_lp), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .hdr_push(hdr_push), .hdr_data(hdr_data),
    .pay_push(pay_push), .pay_data(pay_data), .drain_evt(drain_evt),
    .done_valid(done_valid), .done_code(done_code));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [5:0] t);
    case (t)
      6'h03, 6'h13, 6'h23, 6'h05, 6'h15, 6'h37,
      6'h02, 6'h12, 6'h22, 6'h32:                 return 0;
      6'h29, 6'h39:                               return 1;
      6'h01, 6'h11, 6'h21, 6'h31, 6'h08, 6'h09,
      6'h19, 6'h0E, 6'h1E, 6'h2E, 6'h3E:          return 2;
      default:                                    return 3;
    endcase
  endfunction

  function automatic logic [5:0] pick_type(input int i);
    case (i % 25)
      0: return 6'h03;  1: return 6'h13;  2: return 6'h23;  3: return 6'h05;
      4: return 6'h15;  5: return 6'h37;  6: return 6'h02;  7: return 6'h12;
      8: return 6'h22;  9: return 6'h32;  10: return 6'h29; 11: return 6'h39;
      12: return 6'h29; 13: return 6'h39; 14: return 6'h01; 15: return 6'h11;
      16: return 6'h21; 17: return 6'h31; 18: return 6'h08; 19: return 6'h09;
      20: return 6'h19; 21: return 6'h0E; 22: return 6'h1E; 23: return 6'h3E;
      default: return 6'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int i, input int len);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (4*i + k < len) w[8*k +: 8] = pay[4*i + k];
    return w;
  endfunction

  task automatic run(input logic [5:0] t, input int len, input logic [7:0] p0,
                     input logic [7:0] p1, input bit lp, input int edelay);
    int kd = kind_of(t);
    int ecode, ewords, ehdrs, nw = 0, nh = 0, idx = 0, hcnt = 0;
    bit fire = 0, hseen = 0, fin = 0;
    logic [23:0] ehdr;
    ecode  = lp ? 3 : (kd == 0) ? 0 : (kd == 2) ? 1 : (kd == 3) ? 2 : (edelay < TMO ? 0 : 4);
    ewords = (!lp && kd == 1) ? (len + 3) / 4 : 0;
    ehdrs  = (!lp && kd <= 1) ? 1 : 0;
    ehdr   = (kd == 0) ? {p1, p0, 2'b00, t} : {len[15:8], len[7:0], 2'b00, t};
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_type = t; req_len = 16'(len);
    req_p0 = p0; req_p1 = p1; link_lp = lp;
    @(negedge clk);
    req_valid = 1'b0; link_lp = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (fire) idx++;
      if (pay_push) begin
        chk(nw < ewords && !hseen, "R3 payload before header / count", 32'(nw), 32'(ewords));
        chk(pay_data == exp_word(nw, len), (4*nw + 4 > len) ? "R2 zero-filled tail word" : "R1 packed word",
            pay_data, exp_word(nw, len));
        nw++;
      end
      if (hdr_push) begin
        chk(hdr_data == ehdr, kd == 0 ? "R4 short header" : "R3 long header", 32'(hdr_data), 32'(ehdr));
        nh++; hseen = 1; hcnt = 0;
      end
      if (done_valid) begin
        chk(32'(done_code) == 32'(ecode),
            lp ? "R9 low-power status" : kd == 2 ? "R7 refused status" : kd == 3 ? "R8 unknown status" :
            kd == 0 ? "R4 short status" : ecode == 4 ? "R6 timeout status" : "R5 drain status",
            32'(done_code), 32'(ecode));
        chk(nw == ewords, lp ? "R9 no payload" : "R7 R8 payload count", 32'(nw), 32'(ewords));
        chk(nh == ehdrs, lp ? "R9 no header" : "R4 R7 R8 header count", 32'(nh), 32'(ehdrs));
        chk(req_ready == 1'b1, "R10 ready with status", 32'(req_ready), 32'd1);
        fin = 1;
      end
      byte_valid = (idx < len) && ($urandom % 4 != 0);
      byte_data  = pay[idx % 512];
      fire       = byte_valid && byte_ready;
      drain_evt  = hseen && kd == 1 && hcnt == edelay;
      if (hseen) hcnt++;
    end
    if (!fin) chk(1'b0, "R10 no status returned", 0, 1);
    byte_valid = 1'b0; drain_evt = 1'b0;
    @(negedge clk);
    chk(done_valid == 1'b0, "R10 single status pulse", 32'(done_valid), 32'd0);
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len && i < 512; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && !hdr_push && !pay_push && !done_valid, "R11 reset state",
        {28'd0, req_ready, hdr_push, pay_push, done_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !done_valid, "R11 idle after reset", 32'(req_ready), 32'd1);
    for (int n = 0; n <= 8; n++) begin
      fill(n);
      run((n % 2) ? 6'h29 : 6'h39, n, 8'h00, 8'h00, 1'b0, 3);
    end
    fill(300);
    run(6'h39, 300, 8'h00, 8'h00, 1'b0, 0);
    fill(6);
    run(6'h29, 6, 8'h00, 8'h00, 1'b0, TMO - 1);
    fill(6);
    run(6'h29, 6, 8'h00, 8'h00, 1'b0, TMO);
    run(6'h39, 0, 8'h00, 8'h00, 1'b0, TMO + 20);
    for (int i = 0; i < 10; i++) run(pick_type(i), 0, 8'hA5 ^ 8'(i), 8'h3C + 8'(i), 1'b0, 0);
    for (int i = 14; i < 24; i++) run(pick_type(i), 5, 8'h11, 8'h22, 1'b0, 0);
    run(6'h3F, 4, 8'h00, 8'h00, 1'b0, 0);
    run(6'h04, 4, 8'h00, 8'h00, 1'b0, 0);
    fill(7);
    run(6'h29, 7, 8'h00, 8'h00, 1'b1, 0);
    run(6'h05, 0, 8'h10, 8'h00, 1'b1, 0);
    for (int i = 0; i < 70; i++) begin
      int len = $urandom % 41;
      int dly = ($urandom % 5 == 0) ? TMO + ($urandom % 8) : $urandom % TMO;
      fill(len);
      run(pick_type($urandom % 25), len, 8'($urandom), 8'($urandom), ($urandom % 12 == 0), dly);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule